// File: doc/BRIEF.md
# Prefetch Issue Tracking FIFO

This block remembers the prefetches a cache has recently issued so that each one can later be credited as useful or useless to the code region that caused it. Each issued prefetch pushes one record holding its block address, the identifier of the triggering code region and its position inside the prefetch stream. Because the record lives here, the cache lines themselves carry no profiling bits.

Two events look a record up by block address. A demand hit on a prefetched line marks the prefetch useful. The eviction of a prefetched line that was never used marks it useless. All live records are compared against the address at once. A hit returns the region identifier, the stream position and the outcome one cycle later and retires the record. Records are replaced strictly in push order. A record that is overwritten before any lookup reaches it is dropped and gives no outcome.

Top module: `prf_trk_fifo`

## Requirements
- R1: After reset no record is live: `res_valid` is 0, and any lookup misses.
- R2: A push stores address, region and stream position. A later lookup of that address raises `res_valid` in the cycle after the lookup, with `res_region` and `res_pos` equal to the pushed values.
- R3: `res_useful` equals the `lkp_demand` value of the lookup that produced the result: 1 means a demand hit (useful), 0 means an eviction (useless).
- R4: A lookup that hits retires the matched record. A second lookup of the same address then misses, unless another live record holds that address.
- R5: A lookup that misses leaves `res_valid` at 0 and changes no record. Other records stay retrievable.
- R6: Records sit in a ring of DEPTH (64) slots that is written in push order. A record survives DEPTH-1 later pushes and is overwritten by the DEPTH-th, after which its address misses and no result is produced for it.
- R7: When several live records hold the same address, a lookup returns the most recently pushed one. The older ones stay for later lookups.
- R8: When a push and a lookup happen in the same cycle, both are served. The lookup sees only the records that were live before that cycle, and the pushed record is live from the next cycle.
- R9: The stream position is a 4-bit field carrying values 0 to 15 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Record a newly issued prefetch |
| push_addr | input | 26 | Block address of the prefetch |
| push_region | input | 26 | Identifier of the triggering code region |
| push_pos | input | 4 | Position in the prefetch stream (0..15) |
| lkp_valid | input | 1 | Look up a prefetched block |
| lkp_addr | input | 26 | Block address to look up |
| lkp_demand | input | 1 | 1 = demand hit (useful), 0 = unused eviction (useless) |
| res_valid | output | 1 | Lookup hit; result fields are valid |
| res_region | output | 26 | Region identifier of the matched record |
| res_pos | output | 4 | Stream position of the matched record |
| res_useful | output | 1 | Outcome flag for the matched prefetch |

## Verification
A wrong live bit or write pointer stays hidden until a lookup reaches the affected slot. A bit lost to a bad clear turns a later hit into a missing `res_valid`. A bit left set after a hit makes a repeated lookup return a stale record. A slipped pointer shows up DEPTH pushes later, when a record that should be gone still answers or one that should remain has vanished. A wrong age order among duplicate addresses shows up at once as the older record's region and position on the result. The bench keeps many duplicates and long push runs in play so that each of these faults shows at the ports within a few dozen cycles of its cause.

// File: rtl/prf_trk_pkg.sv
package prf_trk_pkg;

    typedef enum logic {
        OUTCOME_USELESS = 1'b0,
        OUTCOME_USEFUL  = 1'b1
    } outcome_e;

    // Advance a ring index with an explicit wrap, so the depth need not be a power of two.
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
        return (idx + 1 >= depth) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/prf_trk_cam.sv
module prf_trk_cam #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 26
) (
    input  logic [DEPTH-1:0]  live,
    input  logic [ADDR_W-1:0] tags [DEPTH],
    input  logic [ADDR_W-1:0] key,
    output logic [DEPTH-1:0]  match
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = live[g] && (tags[g] == key);
    end

endmodule

// File: rtl/prf_trk_pick.sv
module prf_trk_pick #(
    parameter int DEPTH = 64,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] match,
    input  logic [PTR_W-1:0] oldest,
    output logic             hit,
    output logic [PTR_W-1:0] sel_idx,
    output logic [DEPTH-1:0] sel_vec
);

    // Walk from the oldest slot to the newest; the last match seen is the youngest.
    always_comb begin
        int unsigned pos;
        hit     = 1'b0;
        sel_idx = '0;
        sel_vec = '0;
        pos     = int'(oldest);
        for (int k = 0; k < DEPTH; k++) begin
            if (match[pos]) begin
                hit     = 1'b1;
                sel_idx = PTR_W'(pos);
            end
            pos = prf_trk_pkg::ring_next(pos, DEPTH);
        end
        if (hit) sel_vec[sel_idx] = 1'b1;
    end

    AST_PICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_vec)) else $error("more than one slot selected");       // R7
    AST_PICK_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (sel_vec & match) == sel_vec) else $error("selected slot does not match"); // R7
    AST_PICK_HIT_IFF: assert property (@(posedge clk) disable iff (!rst_n)
        hit == (match != '0)) else $error("hit flag disagrees with matches");  // R5

endmodule

// File: rtl/prf_trk_fifo.sv
module prf_trk_fifo #(
    parameter int DEPTH    = 64,
    parameter int ADDR_W   = 26,
    parameter int REGION_W = 26,
    parameter int POS_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_valid,
    input  logic [ADDR_W-1:0]   push_addr,
    input  logic [REGION_W-1:0] push_region,
    input  logic [POS_W-1:0]    push_pos,
    input  logic                lkp_valid,
    input  logic [ADDR_W-1:0]   lkp_addr,
    input  logic                lkp_demand,
    output logic                res_valid,
    output logic [REGION_W-1:0] res_region,
    output logic [POS_W-1:0]    res_pos,
    output logic                res_useful
);
    import prf_trk_pkg::*;

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0]    live;
        logic [PTR_W-1:0]    wptr;
        logic                rvalid;
        logic [REGION_W-1:0] rregion;
        logic [POS_W-1:0]    rpos;
        outcome_e            rout;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [ADDR_W-1:0]   addr_d   [DEPTH];
    logic [ADDR_W-1:0]   addr_q   [DEPTH];
    logic [REGION_W-1:0] region_d [DEPTH];
    logic [REGION_W-1:0] region_q [DEPTH];
    logic [POS_W-1:0]    pos_d    [DEPTH];
    logic [POS_W-1:0]    pos_q    [DEPTH];

    logic [DEPTH-1:0] match;
    logic             hit;
    logic [PTR_W-1:0] sel_idx;
    logic [DEPTH-1:0] sel_vec;

    prf_trk_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) cam_i (
        .live  (ctl_q.live),
        .tags  (addr_q),
        .key   (lkp_addr),
        .match (match)
    );

    // The write pointer names the slot written longest ago, hence the oldest.
    prf_trk_pick #(.DEPTH(DEPTH), .PTR_W(PTR_W)) pick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .match   (match),
        .oldest  (ctl_q.wptr),
        .hit     (hit),
        .sel_idx (sel_idx),
        .sel_vec (sel_vec)
    );

    always_comb begin
        ctl_d    = ctl_q;
        addr_d   = addr_q;
        region_d = region_q;
        pos_d    = pos_q;

        ctl_d.rvalid = lkp_valid && hit;
        if (lkp_valid && hit) begin
            ctl_d.live[sel_idx] = 1'b0;
            ctl_d.rregion       = region_q[sel_idx];
            ctl_d.rpos          = pos_q[sel_idx];
            ctl_d.rout          = lkp_demand ? OUTCOME_USEFUL : OUTCOME_USELESS;
        end

        // The push comes after the retire so a new record survives a clear of its slot.
        if (push_valid) begin
            addr_d[ctl_q.wptr]     = push_addr;
            region_d[ctl_q.wptr]   = push_region;
            pos_d[ctl_q.wptr]      = push_pos;
            ctl_d.live[ctl_q.wptr] = 1'b1;
            ctl_d.wptr = (ctl_q.wptr == LAST_SLOT) ? '0 : ctl_q.wptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        addr_q   <= addr_d;
        region_q <= region_d;
        pos_q    <= pos_d;
    end

    assign res_valid  = ctl_q.rvalid;
    assign res_region = ctl_q.rregion;
    assign res_pos    = ctl_q.rpos;
    assign res_useful = (ctl_q.rout == OUTCOME_USEFUL);

    AST_RES_NEEDS_LKP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(lkp_valid)) else $error("result without lookup");       // R5
    AST_RES_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_useful == $past(lkp_demand)) else $error("wrong outcome"); // R3
    AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && !hit && !push_valid) |=> $stable(ctl_q.live)) else $error("miss changed state"); // R5
    AST_HIT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && hit && !push_valid) |=> $countones(ctl_q.live) == $past($countones(ctl_q.live)) - 1)
        else $error("hit did not retire one record");                               // R4
    AST_PUSH_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> ctl_q.live[$past(ctl_q.wptr)]) else $error("pushed slot not live"); // R8
    AST_RESET_EMPTY: assert property (@(posedge clk)
        $past(!rst_n) |-> (ctl_q.live == '0 && !res_valid)) else $error("reset left state"); // R1

endmodule

// File: tb/prf_trk_fifo_tb.sv
module prf_trk_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int AW = 26;
    localparam int RW = 26;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_valid = 1'b0;
    logic [AW-1:0] push_addr = '0;
    logic [RW-1:0] push_region = '0;
    logic [PW-1:0] push_pos = '0;
    logic          lkp_valid = 1'b0;
    logic [AW-1:0] lkp_addr = '0;
    logic          lkp_demand = 1'b0;
    logic          res_valid;
    logic [RW-1:0] res_region;
    logic [PW-1:0] res_pos;
    logic          res_useful;

    always #(CLK_PERIOD/2) clk = ~clk;

    prf_trk_fifo dut_i (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_addr(push_addr), .push_region(push_region), .push_pos(push_pos),
        .lkp_valid(lkp_valid), .lkp_addr(lkp_addr), .lkp_demand(lkp_demand),
        .res_valid(res_valid), .res_region(res_region), .res_pos(res_pos), .res_useful(res_useful)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Reference model built from the requirements.
    logic [AW-1:0] m_addr [DEPTH];
    logic [RW-1:0] m_reg  [DEPTH];
    logic [PW-1:0] m_pos  [DEPTH];
    bit            m_live [DEPTH];
    int            m_wp;

    function automatic int model_find(input logic [AW-1:0] a);
        int found = -1;
        for (int k = 0; k < DEPTH; k++) begin
            int idx = (m_wp + k) % DEPTH;
            if (m_live[idx] && m_addr[idx] == a) found = idx;
        end
        return found;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) m_live[i] = 1'b0;
        m_wp = 0;
    endtask

    task automatic check(input string req, input bit cond, input string what);
        n_checks++;
        if (!cond) begin
            n_fails++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    // One cycle: inputs driven at the falling edge, result sampled at the next falling edge.
    task automatic step(input bit pv, input logic [AW-1:0] pa, input logic [RW-1:0] pr,
                        input logic [PW-1:0] pp, input bit lv, input logic [AW-1:0] la,
                        input bit ld, input string req);
        int hit_idx;
        bit e_v;
        logic [RW-1:0] e_r;
        logic [PW-1:0] e_p;
        push_valid = pv; push_addr = pa; push_region = pr; push_pos = pp;
        lkp_valid = lv; lkp_addr = la; lkp_demand = ld;
        hit_idx = lv ? model_find(la) : -1;
        e_v = (hit_idx >= 0);
        e_r = e_v ? m_reg[hit_idx] : '0;
        e_p = e_v ? m_pos[hit_idx] : '0;
        if (e_v) m_live[hit_idx] = 1'b0;
        if (pv) begin
            m_addr[m_wp] = pa; m_reg[m_wp] = pr; m_pos[m_wp] = pp; m_live[m_wp] = 1'b1;
            m_wp = (m_wp + 1) % DEPTH;
        end
        @(posedge clk);
        @(negedge clk);
        push_valid = 1'b0; lkp_valid = 1'b0;
        check(req, res_valid === e_v,
              $sformatf("res_valid act=%0b exp=%0b addr=%0h", res_valid, e_v, la));
        if (e_v && res_valid === 1'b1) begin
            check(req, res_region === e_r, $sformatf("res_region act=%0h exp=%0h", res_region, e_r));
            check(req, res_pos === e_p, $sformatf("res_pos act=%0d exp=%0d", res_pos, e_p));
            check("R3", res_useful === ld, $sformatf("res_useful act=%0b exp=%0b", res_useful, ld));
        end
    endtask

    task automatic do_push(input logic [AW-1:0] a, input logic [RW-1:0] r, input logic [PW-1:0] p, input string req);
        step(1'b1, a, r, p, 1'b0, '0, 1'b0, req);
    endtask

    task automatic do_look(input logic [AW-1:0] a, input bit d, input string req);
        step(1'b0, '0, '0, '0, 1'b1, a, d, req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4242));
        model_clear();
        repeat (3) @(negedge clk);
        check("R1", res_valid === 1'b0, $sformatf("res_valid in reset act=%0b exp=0", res_valid));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", res_valid === 1'b0, $sformatf("res_valid after reset act=%0b exp=0", res_valid));
        do_look(26'h0, 1'b1, "R1");
        do_look(26'h1234, 1'b0, "R1");

        // R2, R3, R9: basic store and retrieve, both outcomes, position limits.
        do_push(26'h3AB_CDE1, 26'h111_1111, 4'd15, "R9");
        do_push(26'h000_0042, 26'h222_2222, 4'd0, "R9");
        do_look(26'h3AB_CDE1, 1'b1, "R2");
        do_look(26'h000_0042, 1'b0, "R3");
        // R4: retired records miss.
        do_look(26'h3AB_CDE1, 1'b1, "R4");
        // R5: a miss leaves others intact.
        do_push(26'h0AA_0001, 26'h333_0001, 4'd7, "R5");
        do_look(26'h0BB_0002, 1'b1, "R5");
        do_look(26'h0AA_0001, 1'b1, "R5");
        // R7: duplicates, newest first, then older.
        do_push(26'h055_5555, 26'h000_00A1, 4'd1, "R7");
        do_push(26'h055_5555, 26'h000_00A2, 4'd2, "R7");
        do_push(26'h055_5555, 26'h000_00A3, 4'd3, "R7");
        do_look(26'h055_5555, 1'b1, "R7");
        do_look(26'h055_5555, 1'b0, "R7");
        do_look(26'h055_5555, 1'b1, "R7");
        do_look(26'h055_5555, 1'b1, "R7");
        // R8: same-cycle push and lookup of a new address: lookup misses, record lives next.
        step(1'b1, 26'h077_0000, 26'h000_0BEE, 4'd9, 1'b1, 26'h077_0000, 1'b1, "R8");
        do_look(26'h077_0000, 1'b0, "R8");
        // R8: same-cycle push of a duplicate while looking up the older copy.
        do_push(26'h078_0000, 26'h000_0C01, 4'd4, "R8");
        step(1'b1, 26'h078_0000, 26'h000_0C02, 4'd5, 1'b1, 26'h078_0000, 1'b1, "R8");
        do_look(26'h078_0000, 1'b0, "R8");
        // R6: survives DEPTH-1 later pushes, dropped at the DEPTH-th.
        do_push(26'h100_0000, 26'h000_0F00, 4'd6, "R6");
        for (int i = 1; i < DEPTH; i++) do_push(26'h200_0000 + i, 26'h000_1000 + i, PW'(i), "R6");
        do_look(26'h100_0000, 1'b1, "R6");
        do_push(26'h101_0000, 26'h000_0F01, 4'd8, "R6");
        for (int i = 0; i < DEPTH; i++) do_push(26'h300_0000 + i, 26'h000_2000 + i, PW'(i), "R6");
        do_look(26'h101_0000, 1'b1, "R6");
        do_look(26'h300_0000, 1'b0, "R6");

        // Random phase over a small address pool so hits, duplicates and overwrites are frequent.
        for (int n = 0; n < 3000; n++) begin
            bit pv = ($urandom_range(0, 99) < 60);
            bit lv = ($urandom_range(0, 99) < 55);
            logic [AW-1:0] pa = 26'h3C0_0000 + AW'($urandom_range(0, 23));
            logic [AW-1:0] la = 26'h3C0_0000 + AW'($urandom_range(0, 27));
            step(pv, pa, RW'($urandom), PW'($urandom_range(0, 15)), lv, la, 1'($urandom), "R7");
        end

        // Reset mid-run empties the table.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        @(negedge clk);
        do_look(26'h3C0_0001, 1'b1, "R1");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule